// File: doc/BRIEF.md
# ECC Error Control and Status Register Block

This block is a 32-bit AXI4-Lite register slave that runs alongside a memory controller's data path. On the read side it observes per-sub-beat correctable and uncorrectable error flags. When the first failure arrives, it records the failing byte address, data word and check bits. It counts correctable errors in a saturating counter and raises one interrupt line, which software can enable separately for each error kind. It also drives the decoder's enable input from a single on/off control bit. The encoder is never switched off.

On the write side, the block holds up to four 32-bit fault-injection masks. It XORs these masks into the encoded write word, but only on the first beat of each burst, so that software can plant known errors in memory. The masks are present only when the `FI_EN` parameter is set. When the control bit is off, the status bits and the counter no longer follow the error flags, and the injection masks cannot be written.

Register map (word offsets in bytes): 0x00 control (bit 0 decode on), 0x04 interrupt enable (bit 0 correctable, bit 1 uncorrectable), 0x08 status (bit 0 correctable, bit 1 uncorrectable; write 1 to clear), 0x0C correctable count, 0x10 failing address, 0x14 failing data, 0x18 failing check bits, 0x20/0x24/0x28/0x2C injection masks 0 to 3. Mask 0 covers encoded bits 31:0 and mask 1 covers the bits above that.

Top module: `ecc_csr`

## Requirements
- R1: Each write address/data pair accepted together yields exactly one write response, and each read address yields one read response on the following cycle. Both responses are OKAY (2'b00), and a read of an unmapped offset (for example 0x1C) returns zero.
- R2: After reset, control bit 0 holds the parameter `ECC_ON_RST`. The `decode_en` output always equals that bit: writing 1 to it raises `decode_en` and writing 0 lowers it.
- R3: While control bit 0 is 0, error flags set no status bit and leave the correctable count unchanged.
- R4: While control bit 0 is 0, writes to the injection mask registers (0x20 to 0x2C) are ignored, and a readback returns the previous value.
- R5: Any correctable flag sets status bit 0 and any uncorrectable flag sets status bit 1, one cycle after the flag. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R6: The failing address, data and check bits are captured on an error only while both status bits are clear. They stay unchanged until software has cleared both bits.
- R7: The correctable count rises by the number of asserted correctable flags in a cycle. It stops at its maximum value (15 with `CNT_W`=4) and does not wrap.
- R8: `irq` is high exactly when (status bit 0 and enable bit 0) or (status bit 1 and enable bit 1).
- R9: With `wr_first` high, `wr_enc_o` equals `wr_enc_i` XOR the mask registers. With `wr_first` low, `wr_enc_o` equals `wr_enc_i`. Masks read back as written while decode is on.
- R10: With `FI_EN`=0, the mask registers read zero and `wr_enc_o` always equals `wr_enc_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awaddr | input | AW | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | AW | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| err_single | input | BEATS | Correctable flag per sub-beat |
| err_multi | input | BEATS | Uncorrectable flag per sub-beat |
| err_addr | input | 32 | Byte address of the current read |
| err_data | input | DATA_W | Data word of the current read |
| err_chk | input | CHK_W | Check bits of the current read |
| wr_first | input | 1 | Current write word is the first beat of its burst |
| wr_enc_i | input | DATA_W+CHK_W | Encoded write word from the encoder |
| wr_enc_o | output | DATA_W+CHK_W | Write word after fault injection |
| decode_en | output | 1 | Enables the ECC decoder |
| irq | output | 1 | Error interrupt |

## Verification
A corrupt status bit shows on `irq` in the same cycle that the status register updates, provided the matching enable is set. A corrupt mask shows on `wr_enc_o` at the next first beat. Both are compared against the reference on every clock. Faults in capture, counter saturation or write locking are visible only through register reads. The bench therefore reads the affected register right after each error burst, clear or locked write, so a fault surfaces within a few cycles of its cause.

// File: rtl/ecc_csr.sv
module ecc_csr #(
  parameter int AW         = 6,
  parameter int BEATS      = 2,
  parameter int DATA_W     = 32,
  parameter int CHK_W      = 8,
  parameter int CNT_W      = 4,
  parameter bit ECC_ON_RST = 1'b1,
  parameter bit FI_EN      = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [AW-1:0]           s_awaddr,
  input  logic                    s_awvalid,
  output logic                    s_awready,
  input  logic [31:0]             s_wdata,
  input  logic [3:0]              s_wstrb,
  input  logic                    s_wvalid,
  output logic                    s_wready,
  output logic [1:0]              s_bresp,
  output logic                    s_bvalid,
  input  logic                    s_bready,
  input  logic [AW-1:0]           s_araddr,
  input  logic                    s_arvalid,
  output logic                    s_arready,
  output logic [31:0]             s_rdata,
  output logic [1:0]              s_rresp,
  output logic                    s_rvalid,
  input  logic                    s_rready,
  input  logic [BEATS-1:0]        err_single,
  input  logic [BEATS-1:0]        err_multi,
  input  logic [31:0]             err_addr,
  input  logic [DATA_W-1:0]       err_data,
  input  logic [CHK_W-1:0]        err_chk,
  input  logic                    wr_first,
  input  logic [DATA_W+CHK_W-1:0] wr_enc_i,
  output logic [DATA_W+CHK_W-1:0] wr_enc_o,
  output logic                    decode_en,
  output logic                    irq
);
  localparam int EW = DATA_W + CHK_W;
  localparam int IW = AW - 2;
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic             on_q;
  logic [1:0]       ien_q, st_q;
  logic [CNT_W-1:0] cnt_q, cnt_nx;
  logic [CNT_W:0]   cnt_sum;
  logic [31:0]      fa_q;
  logic [DATA_W-1:0] fd_q;
  logic [CHK_W-1:0] fc_q;
  logic [3:0][31:0] fi_q;
  logic [127:0]     fi_flat;
  logic [31:0]      bm, wm, rd_w;
  logic [1:0]       clr;

  wire unused_ok = &{1'b0, s_awaddr[1:0], s_araddr[1:0]};
  wire [IW-1:0] widx = s_awaddr[AW-1:2];
  wire [IW-1:0] ridx = s_araddr[AW-1:2];
  wire wr_go  = s_awvalid & s_wvalid & ~s_bvalid;
  wire ce_hit = on_q & (|err_single);
  wire ue_hit = on_q & (|err_multi);
  wire cap    = (ce_hit | ue_hit) & (st_q == 2'b00);

  assign s_awready = wr_go;
  assign s_wready  = wr_go;
  assign s_arready = ~s_rvalid;
  assign s_bresp   = 2'b00;
  assign s_rresp   = 2'b00;
  assign decode_en = on_q;
  assign irq       = |(st_q & ien_q);
  assign fi_flat   = fi_q;
  assign wr_enc_o  = wr_enc_i ^ ({EW{wr_first}} & fi_flat[EW-1:0]);
  assign wm        = s_wdata & bm;
  assign clr       = (wr_go && widx == IW'(2)) ? wm[1:0] : 2'b00;
  assign cnt_nx    = (cnt_sum > {1'b0, CMAX}) ? CMAX : cnt_sum[CNT_W-1:0];

  always_comb begin
    for (int i = 0; i < 4; i++) bm[8*i +: 8] = {8{s_wstrb[i]}};
    cnt_sum = {1'b0, cnt_q};
    for (int i = 0; i < BEATS; i++) cnt_sum += (CNT_W+1)'(err_single[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      on_q  <= ECC_ON_RST;
      ien_q <= '0;
      st_q  <= '0;
      cnt_q <= '0;
      fa_q  <= '0;
      fd_q  <= '0;
      fc_q  <= '0;
    end else begin
      if (wr_go && s_wstrb[0]) begin
        if (widx == IW'(0)) on_q  <= s_wdata[0];
        if (widx == IW'(1)) ien_q <= s_wdata[1:0];
      end
      st_q <= (st_q & ~clr) | {ue_hit, ce_hit};
      if (ce_hit) cnt_q <= cnt_nx;
      if (cap) begin
        fa_q <= err_addr;
        fd_q <= err_data;
        fc_q <= err_chk;
      end
    end
  end

  generate
    if (FI_EN) begin : g_fi
      for (genvar k = 0; k < 4; k++) begin : g_reg
        always_ff @(posedge clk) begin
          if (!rst_n) fi_q[k] <= '0;
          else if (wr_go && on_q && widx == IW'(8 + k))
            fi_q[k] <= (fi_q[k] & ~bm) | wm;
        end
      end
    end else begin : g_nofi
      assign fi_q = '0;
    end
  endgenerate

  always_comb begin
    case (ridx)
      IW'(0):  rd_w = {31'b0, on_q};
      IW'(1):  rd_w = {30'b0, ien_q};
      IW'(2):  rd_w = {30'b0, st_q};
      IW'(3):  rd_w = 32'(cnt_q);
      IW'(4):  rd_w = fa_q;
      IW'(5):  rd_w = 32'(fd_q);
      IW'(6):  rd_w = 32'(fc_q);
      IW'(8):  rd_w = fi_q[0];
      IW'(9):  rd_w = fi_q[1];
      IW'(10): rd_w = fi_q[2];
      IW'(11): rd_w = fi_q[3];
      default: rd_w = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_bvalid <= 1'b0;
      s_rvalid <= 1'b0;
      s_rdata  <= '0;
    end else begin
      if (wr_go) s_bvalid <= 1'b1;
      else if (s_bready) s_bvalid <= 1'b0;
      if (s_arvalid && s_arready) begin
        s_rvalid <= 1'b1;
        s_rdata  <= rd_w;
      end else if (s_rready) s_rvalid <= 1'b0;
    end
  end
endmodule

// File: rtl/ecc_csr_chk.sv
module ecc_csr_chk #(
  parameter int CNT_W = 4,
  parameter int EW    = 40
) (
  input logic             clk,
  input logic             rst_n,
  input logic             on_q,
  input logic [1:0]       st_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic [31:0]      fa_q,
  input logic [3:0][31:0] fi_q,
  input logic             s_bvalid,
  input logic             s_bready,
  input logic             s_rvalid,
  input logic             s_rready,
  input logic             irq,
  input logic             wr_first,
  input logic [EW-1:0]    wr_enc_i,
  input logic [EW-1:0]    wr_enc_o
);
  p_bresp_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    s_bvalid && !s_bready |=> s_bvalid);
  p_rresp_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    s_rvalid && !s_rready |=> s_rvalid);
  p_cnt_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !on_q |=> $stable(cnt_q));
  p_st_noset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !on_q |=> ((st_q & ~$past(st_q)) == 2'b00));
  p_fi_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !on_q |=> $stable(fi_q));
  p_capture_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != 2'b00) |=> $stable(fa_q));
  p_cnt_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '1) |=> (cnt_q == '1));
  p_irq_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (st_q != 2'b00));
  p_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_first |-> (wr_enc_o == wr_enc_i));
endmodule

bind ecc_csr ecc_csr_chk #(.CNT_W(CNT_W), .EW(DATA_W + CHK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .on_q(on_q), .st_q(st_q), .cnt_q(cnt_q),
  .fa_q(fa_q), .fi_q(fi_q), .s_bvalid(s_bvalid), .s_bready(s_bready),
  .s_rvalid(s_rvalid), .s_rready(s_rready), .irq(irq),
  .wr_first(wr_first), .wr_enc_i(wr_enc_i), .wr_enc_o(wr_enc_o)
);

// File: tb/sim_ecc_csr.sv
`timescale 1ns/1ps
module sim_ecc_csr;
  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic [5:0] awaddr = 0, araddr = 0;
  logic awvalid = 0, wvalid = 0, arvalid = 0;
  logic [31:0] wdata = 0;
  logic [3:0] wstrb = 4'hF;
  logic [1:0] es = 0, em = 0;
  logic [31:0] eaddr = 0, edata = 0;
  logic [7:0] echk = 0;
  logic wfirst = 0;
  logic [39:0] wenc = 0;
  wire awready, wready, bvalid, arready, rvalid, dec, irq;
  wire [1:0] bresp, rresp;
  wire [31:0] rdata;
  wire [39:0] wout;
  wire awready1, wready1, bvalid1, arready1, rvalid1, dec1, irq1;
  wire [1:0] bresp1, rresp1;
  wire [31:0] rdata1;
  wire [39:0] wout1;

  ecc_csr u0 (.clk, .rst_n, .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
    .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready), .s_bresp(bresp),
    .s_bvalid(bvalid), .s_bready(1'b1), .s_araddr(araddr), .s_arvalid(arvalid),
    .s_arready(arready), .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(1'b1),
    .err_single(es), .err_multi(em), .err_addr(eaddr), .err_data(edata), .err_chk(echk),
    .wr_first(wfirst), .wr_enc_i(wenc), .wr_enc_o(wout), .decode_en(dec), .irq(irq));

  ecc_csr #(.ECC_ON_RST(1'b0), .FI_EN(1'b0)) u1 (.clk, .rst_n, .s_awaddr(awaddr),
    .s_awvalid(awvalid), .s_awready(awready1), .s_wdata(wdata), .s_wstrb(wstrb),
    .s_wvalid(wvalid), .s_wready(wready1), .s_bresp(bresp1), .s_bvalid(bvalid1),
    .s_bready(1'b1), .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready1),
    .s_rdata(rdata1), .s_rresp(rresp1), .s_rvalid(rvalid1), .s_rready(1'b1),
    .err_single(es), .err_multi(em), .err_addr(eaddr), .err_data(edata), .err_chk(echk),
    .wr_first(wfirst), .wr_enc_i(wenc), .wr_enc_o(wout1), .decode_en(dec1), .irq(irq1));

  int tests = 0, fails = 0;
  bit done = 0;
  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference of u0
  bit m_on; bit [1:0] m_ien, m_st; int m_cnt;
  logic [31:0] m_addr, m_data, m_fi[4]; logic [7:0] m_chk;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_on = 1; m_ien = 0; m_st = 0; m_cnt = 0; m_addr = 0; m_data = 0; m_chk = 0;
      foreach (m_fi[i]) m_fi[i] = 0;
    end else begin
      automatic bit old_on = m_on;
      automatic bit ce = old_on && es != 0;
      automatic bit ue = old_on && em != 0;
      automatic int idx = awaddr / 4;
      automatic bit [1:0] cl = 0;
      automatic logic [31:0] msk = {{8{wstrb[3]}}, {8{wstrb[2]}}, {8{wstrb[1]}}, {8{wstrb[0]}}};
      if ((ce || ue) && m_st == 0) begin m_addr = eaddr; m_data = edata; m_chk = echk; end
      if (ce) begin m_cnt += es[0] + es[1]; if (m_cnt > 15) m_cnt = 15; end
      if (awvalid && wvalid) begin
        if (idx == 0 && wstrb[0]) m_on = wdata[0];
        if (idx == 1 && wstrb[0]) m_ien = wdata[1:0];
        if (idx == 2) cl = wdata[1:0] & msk[1:0];
        if (idx >= 8 && idx <= 11 && old_on) m_fi[idx-8] = (m_fi[idx-8] & ~msk) | (wdata & msk);
      end
      m_st = (m_st & ~cl) | {ue, ce};
    end
  end

  function automatic logic [31:0] exp_rd(input int idx);
    case (idx)
      0: return {31'b0, m_on};
      1: return {30'b0, m_ien};
      2: return {30'b0, m_st};
      3: return 32'(m_cnt);
      4: return m_addr;
      5: return m_data;
      6: return {24'b0, m_chk};
      8, 9, 10, 11: return m_fi[idx-8];
      default: return 0;
    endcase
  endfunction

  // write-path stimulus: bursts of four beats
  logic [31:0] lfsr = 32'h1;
  int cyc = 0;
  always @(negedge clk) begin
    lfsr <= {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    wfirst <= (cyc % 4 == 0);
    wenc <= {lfsr[15:8], lfsr};
    cyc <= cyc + 1;
  end

  // per-clock comparison against the reference
  always begin
    @(posedge clk); #1;
    if (rst_n && !done) begin
      chk("R2 decode_en", dec, m_on);
      chk("R8 irq", irq, |(m_st & m_ien));
      chk("R9 wr_enc_o", wout, wenc ^ (wfirst ? {m_fi[1][7:0], m_fi[0]} : 40'h0));
      chk("R10 wr_enc_o no-FI", wout1, wenc);
    end
  end

  task automatic wr(input int idx, input logic [31:0] d);
    @(negedge clk); awaddr = 6'(idx * 4); wdata = d; awvalid = 1; wvalid = 1;
    @(negedge clk); awvalid = 0; wvalid = 0;
    chk("R1 bvalid", bvalid, 1); chk("R1 bresp", bresp, 0);
    @(negedge clk);
    chk("R1 bvalid single", bvalid, 0);
  endtask

  task automatic rd(input int idx, input string req, output logic [31:0] d1);
    @(negedge clk); araddr = 6'(idx * 4); arvalid = 1;
    @(negedge clk); arvalid = 0;
    chk("R1 rvalid", rvalid, 1); chk("R1 rresp", rresp, 0);
    chk(req, rdata, exp_rd(idx));
    d1 = rdata1;
    @(negedge clk);
  endtask

  task automatic err(input logic [1:0] s, input logic [1:0] m, input logic [31:0] a);
    @(negedge clk); es = s; em = m; eaddr = a; edata = ~a; echk = a[7:0] ^ 8'h5A;
    @(negedge clk); es = 0; em = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d1;
    repeat (3) @(negedge clk); rst_n = 1;
    rd(0, "R2 reset control", d1); chk("R2 param reset u1", d1, 0);
    rd(2, "R5 reset status", d1);
    rd(3, "R7 reset count", d1);
    rd(7, "R1 unmapped read", d1);
    wr(1, 3);
    wr(8, 32'hDEAD_BEEF); wr(9, 32'h0000_00A5); wr(10, 32'h1234_5678);
    rd(8, "R9 mask0 readback", d1); chk("R10 mask reads zero", d1, 0);
    rd(9, "R9 mask1 readback", d1); rd(10, "R9 mask2 readback", d1);
    repeat (8) @(negedge clk);
    err(2'b01, 2'b00, 32'h0000_1040);
    rd(2, "R5 CE status", d1); rd(3, "R7 count 1", d1);
    rd(4, "R6 addr", d1); rd(5, "R6 data", d1); rd(6, "R6 chk", d1);
    err(2'b00, 2'b10, 32'h0000_2080);
    rd(2, "R5 both status", d1); rd(4, "R6 addr held", d1); rd(5, "R6 data held", d1);
    wr(2, 1); rd(2, "R5 W1C bit0", d1); rd(4, "R6 held one bit set", d1);
    wr(2, 0); rd(2, "R5 write 0 no effect", d1);
    wr(2, 2); rd(2, "R5 W1C bit1", d1);
    err(2'b00, 2'b01, 32'h0000_30C0);
    rd(4, "R6 new capture", d1); rd(2, "R5 UE status", d1);
    wr(2, 3); wr(1, 1);
    err(2'b00, 2'b01, 32'h0000_4000);
    rd(2, "R8 UE masked status", d1);
    wr(2, 3); wr(1, 3);
    wr(0, 0);
    rd(0, "R2 control off", d1);
    err(2'b11, 2'b11, 32'h0000_5000);
    rd(2, "R3 status frozen", d1); rd(3, "R3 count frozen", d1); rd(4, "R3 no capture", d1);
    wr(8, 32'h0BAD_F00D); rd(8, "R4 mask0 locked", d1);
    wr(11, 32'hFFFF_FFFF); rd(11, "R4 mask3 locked", d1);
    wr(0, 1);
    rd(0, "R2 control on", d1);
    wstrb = 4'h1; wr(8, 32'hAAAA_AA11); wstrb = 4'hF;
    rd(8, "R9 strobed mask0", d1);
    for (int i = 0; i < 10; i++) err(2'b11, 2'b00, 32'h0000_6000 + i);
    rd(3, "R7 saturated", d1); chk("R7 saturated value", rdata === 0 ? 0 : exp_rd(3), 15);
    wr(2, 3);
    err(2'b01, 2'b00, 32'h0000_7000);
    rd(3, "R7 no wrap", d1); rd(4, "R6 capture after clear", d1);
    repeat (8) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule